// File: doc/BRIEF.md
# Dual-Bank IDE PIO Timing Controller

This block runs programmed-I/O cycles on one legacy IDE channel that has two drives on it. A 16-bit control word, loaded through a plain configuration port, switches the channel on and picks which of the two classic address windows it answers. The same word holds one shared fast timing bank and a small control group for each drive. Host I/O requests arrive on a valid/ready interface. Each request that falls in the active window becomes one strobed cycle on the drive side: chip selects, a 3-bit register offset, and a read or write strobe. The cycle is followed by a recovery gap.

Only a drive whose fast-select bit is set uses the programmable bank (strobe length and recovery length). Every cycle to any other drive runs with slow compatible timing. The target drive is the one most recently named by a write to the drive/head register. IORDY can stretch the strobe, but only for a drive that has IORDY sampling turned on.

Back-pressure rules: `req_ready` is high only while no cycle is in progress. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must keep its request stable while `req_valid` is high and `req_ready` is low. A request that transfers but is not claimed is consumed with no drive-side activity. Read data comes back as a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `ide_pio_timing_ctl`

## Requirements
- R1: After reset the control word reads 0 (channel off), the drive target is drive 0, `req_ready` is 1, and `busy`, both strobes, both chip selects and `rsp_valid` are 0.
- R2: A configuration write stores all 16 bits, and they read back unchanged on `cfg_rd_data` the next cycle. Bits other than 15, 14, 13:12, 9:8, 1:0 and 5:4 change no cycle timing. This includes the prefetch bits 2 and 6.
- R3: While bit 15 (channel enable) is 0, every transferred request is consumed with no strobe, no chip select and no `busy`.
- R4: With bit 14 at 0, addresses 0x1F0–0x1F7 assert `ide_cs_cmd` with `ide_addr` equal to the address's low 3 bits, and 0x3F6 asserts `ide_cs_ctl` with `ide_addr` = 6. With bit 14 at 1, the same happens for 0x170–0x177 and 0x376. Every other address is consumed with no cycle.
- R5: The target drive is bit 4 of the data of the latest write to command-window offset 6. The cycle that performs that write still uses the previous target. Writes to the control port at offset 6 do not change the target.
- R6: When the target's fast bit is set (bit 0 for drive 0, bit 4 for drive 1), the strobe lasts 5 − bits[13:12] clocks and recovery lasts 4 − bits[9:8] clocks.
- R7: When the target's fast bit is clear, the strobe lasts 8 clocks and recovery lasts 10 clocks.
- R8: If the target's IORDY enable is set (bit 1 for drive 0, bit 5 for drive 1), each clock edge that closes the strobe period and sees `ide_iordy` low extends the strobe by one clock. If the enable is clear, `ide_iordy` has no effect.
- R9: `busy` is high and `req_ready` low from the first strobe clock to the last recovery clock. A request held valid during that time transfers on the first edge with `req_ready` high, and is never accepted while busy.
- R10: For a read, `ide_rdata` is captured on the edge that ends the strobe and presented with a one-clock `rsp_valid` pulse in the first recovery clock.
- R11: During a cycle, exactly one of `ide_rd` (reads) or `ide_wr` (writes) is asserted in its strobe phase. The chip select, `ide_addr` and `ide_wdata` stay constant through the strobe and recovery phases and are cleared when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Load the control word |
| cfg_wr_data | input | 16 | New control word |
| cfg_rd_data | output | 16 | Current control word |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Host I/O address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data |
| busy | output | 1 | Cycle in progress, recovery included |
| ide_cs_cmd | output | 1 | Command-block chip select |
| ide_cs_ctl | output | 1 | Control-block chip select |
| ide_addr | output | 3 | Register offset on the drive bus |
| ide_rd | output | 1 | Read strobe, active high |
| ide_wr | output | 1 | Write strobe, active high |
| ide_wdata | output | 16 | Data driven to the drive |
| ide_rdata | input | 16 | Data from the drive |
| ide_iordy | input | 1 | Drive ready, low requests wait |

## Verification
The bench drives cycles to both address windows, to addresses outside them, and with the channel off. This separates the decoding of bit 15 from the decoding of bit 14. It runs the fast bank at the longest, shortest and middle field codes, and compares each against compatible timing on the same drive, so a swapped or non-inverted field shows up as a wrong strobe or recovery length. Drive-target switching is tried in both directions and through the control port, which exposes an update that lands one cycle early or from the wrong offset. IORDY is held low with the enable on (fast and compatible) and with it off, which shows whether the wait path is gated per drive. Back-to-back requests held valid through `busy` confirm the handshake.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int REG_W          = 16;
  localparam int EN_BIT         = 15;
  localparam int SEC_BIT        = 14;
  localparam int SAMP_LSB       = 12;
  localparam int REC_LSB        = 8;
  localparam int FIELD_W        = 2;
  localparam int GRP_STRIDE     = 4;
  localparam int FAST_OFS       = 0;
  localparam int IORDY_OFS      = 1;
  localparam int DRV_SEL_BIT    = 4;
  localparam logic [2:0] DRVHEAD_OFS = 3'd6;
  localparam int SAMPLE_LONGEST = 5;
  localparam int REC_LONGEST    = 4;
  localparam int COMPAT_ACT     = 8;
  localparam int COMPAT_REC     = 10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RECOV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
  parameter int ADDR_W  = 10,
  parameter int PRI_CMD = 'h1F0,
  parameter int PRI_CTL = 'h3F6,
  parameter int SEC_CMD = 'h170,
  parameter int SEC_CTL = 'h376
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              chan_en,
  input  logic              use_sec,
  output logic              hit_cmd,
  output logic              hit_ctl,
  output logic [2:0]        ofs
);
  localparam logic [ADDR_W-1:0] PCMD = ADDR_W'(PRI_CMD);
  localparam logic [ADDR_W-1:0] PCTL = ADDR_W'(PRI_CTL);
  localparam logic [ADDR_W-1:0] SCMD = ADDR_W'(SEC_CMD);
  localparam logic [ADDR_W-1:0] SCTL = ADDR_W'(SEC_CTL);

  logic [ADDR_W-1:0] cmd_base;
  logic [ADDR_W-1:0] ctl_port;

  always_comb begin
    cmd_base = use_sec ? SCMD : PCMD;
    ctl_port = use_sec ? SCTL : PCTL;
    hit_cmd  = chan_en && (addr[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
    hit_ctl  = chan_en && (addr == ctl_port);
    ofs      = addr[2:0];
  end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
  import ide_pio_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NUM_DRV = 2,
  parameter int DRV_W   = 1
) (
  input  logic [NUM_DRV-1:0] fast_bits,
  input  logic [NUM_DRV-1:0] iordy_bits,
  input  logic [DRV_W-1:0]   drive,
  input  logic [FIELD_W-1:0] samp_code,
  input  logic [FIELD_W-1:0] rec_code,
  output logic [CNT_W-1:0]   act_len,
  output logic [CNT_W-1:0]   rec_len,
  output logic               iordy_en
);
  logic use_fast;

  always_comb begin
    use_fast = fast_bits[drive];
    iordy_en = iordy_bits[drive];
    if (use_fast) begin
      act_len = CNT_W'(SAMPLE_LONGEST) - CNT_W'(samp_code);
      rec_len = CNT_W'(REC_LONGEST) - CNT_W'(rec_code);
    end else begin
      act_len = CNT_W'(COMPAT_ACT);
      rec_len = CNT_W'(COMPAT_REC);
    end
  end
endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
  import ide_pio_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic              start_cmd,
  input  logic              start_ctl,
  input  logic [2:0]        start_ofs,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [CNT_W-1:0]  act_len,
  input  logic [CNT_W-1:0]  rec_len,
  input  logic              iordy_en,
  input  logic              iordy,
  input  logic [DATA_W-1:0] rdata,
  output logic              idle,
  output logic              cs_cmd,
  output logic              cs_ctl,
  output logic [2:0]        bus_ofs,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  act_q;
  logic [CNT_W-1:0]  rec_q;
  logic              ien_q;
  logic              we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      act_q     <= '0;
      rec_q     <= '0;
      ien_q     <= 1'b0;
      we_q      <= 1'b0;
      cs_cmd    <= 1'b0;
      cs_ctl    <= 1'b0;
      bus_ofs   <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_ACTIVE;
            cnt_q     <= CNT_W'(1);
            act_q     <= act_len;
            rec_q     <= rec_len;
            ien_q     <= iordy_en;
            we_q      <= start_we;
            cs_cmd    <= start_cmd;
            cs_ctl    <= start_ctl;
            bus_ofs   <= start_ofs;
            bus_wdata <= start_wdata;
          end
        end
        ST_ACTIVE: begin
          if (cnt_q < act_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (!(ien_q && !iordy)) begin
            state_q <= ST_RECOV;
            cnt_q   <= CNT_W'(1);
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_data  <= rdata;
            end
          end
        end
        ST_RECOV: begin
          if (cnt_q < rec_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else begin
            state_q   <= ST_IDLE;
            cs_cmd    <= 1'b0;
            cs_ctl    <= 1'b0;
            bus_ofs   <= '0;
            bus_wdata <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle   = (state_q == ST_IDLE);
  assign rd_stb = (state_q == ST_ACTIVE) && !we_q;
  assign wr_stb = (state_q == ST_ACTIVE) && we_q;
endmodule

// File: rtl/ide_pio_timing_ctl.sv
module ide_pio_timing_ctl
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int NUM_DRV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              ide_cs_cmd,
  output logic              ide_cs_ctl,
  output logic [2:0]        ide_addr,
  output logic              ide_rd,
  output logic              ide_wr,
  output logic [DATA_W-1:0] ide_wdata,
  input  logic [DATA_W-1:0] ide_rdata,
  input  logic              ide_iordy
);
  localparam int LONGEST = (COMPAT_ACT > COMPAT_REC) ? COMPAT_ACT : COMPAT_REC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;

  logic [REG_W-1:0]   ctrl_q;
  logic [DRV_W-1:0]   drive_q;
  logic               hit_cmd, hit_ctl;
  logic [2:0]         ofs;
  logic               seq_idle;
  logic               accept, start;
  logic [NUM_DRV-1:0] fast_bits, iordy_bits;
  logic [CNT_W-1:0]   act_len, rec_len;
  logic               iordy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (cfg_wr_en) ctrl_q <= cfg_wr_data;
  end
  assign cfg_rd_data = ctrl_q;

  ide_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr    (req_addr),
    .chan_en (ctrl_q[EN_BIT]),
    .use_sec (ctrl_q[SEC_BIT]),
    .hit_cmd (hit_cmd),
    .hit_ctl (hit_ctl),
    .ofs     (ofs)
  );

  assign req_ready = seq_idle;
  assign busy      = !seq_idle;
  assign accept    = req_valid && req_ready;
  assign start     = accept && (hit_cmd || hit_ctl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= '0;
    else if (start && req_write && hit_cmd && (ofs == DRVHEAD_OFS))
      drive_q <= DRV_W'(req_wdata[DRV_SEL_BIT +: DRV_W]);
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_grp
    assign fast_bits[d]  = ctrl_q[GRP_STRIDE*d + FAST_OFS];
    assign iordy_bits[d] = ctrl_q[GRP_STRIDE*d + IORDY_OFS];
  end

  ide_timing_select #(.CNT_W(CNT_W), .NUM_DRV(NUM_DRV), .DRV_W(DRV_W)) i_tsel (
    .fast_bits  (fast_bits),
    .iordy_bits (iordy_bits),
    .drive      (drive_q),
    .samp_code  (ctrl_q[SAMP_LSB +: FIELD_W]),
    .rec_code   (ctrl_q[REC_LSB +: FIELD_W]),
    .act_len    (act_len),
    .rec_len    (rec_len),
    .iordy_en   (iordy_en)
  );

  ide_strobe_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_we    (req_write),
    .start_cmd   (hit_cmd),
    .start_ctl   (hit_ctl),
    .start_ofs   (ofs),
    .start_wdata (req_wdata),
    .act_len     (act_len),
    .rec_len     (rec_len),
    .iordy_en    (iordy_en),
    .iordy       (ide_iordy),
    .rdata       (ide_rdata),
    .idle        (seq_idle),
    .cs_cmd      (ide_cs_cmd),
    .cs_ctl      (ide_cs_ctl),
    .bus_ofs     (ide_addr),
    .bus_wdata   (ide_wdata),
    .rd_stb      (ide_rd),
    .wr_stb      (ide_wr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );
endmodule

// File: rtl/ide_pio_timing_chk.sv
module ide_pio_timing_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rd_data,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        busy,
  input logic        ide_cs_cmd,
  input logic        ide_cs_ctl,
  input logic [2:0]  ide_addr,
  input logic        ide_rd,
  input logic        ide_wr
);
  always_comb begin
    if (rst_n == 1'b0) begin
      p_reset_quiet_r1: assert (!busy && !ide_rd && !ide_wr && !rsp_valid);
    end
  end

  p_no_cycle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_rd_data[15]) |=> !busy);

  p_cs_matches_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd || ide_wr) |-> (ide_cs_cmd != ide_cs_ctl));

  p_start_needs_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  p_recovery_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_rd || ide_wr) |-> busy);

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(ide_rd) && !ide_rd && busy));

  p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));

  p_bus_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ide_addr) && $stable(ide_cs_cmd) && $stable(ide_cs_ctl)));
endmodule

bind ide_pio_timing_ctl ide_pio_timing_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_data (cfg_rd_data),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .busy        (busy),
  .ide_cs_cmd  (ide_cs_cmd),
  .ide_cs_ctl  (ide_cs_ctl),
  .ide_addr    (ide_addr),
  .ide_rd      (ide_rd),
  .ide_wr      (ide_wr)
);

// File: tb/test_ide_pio_timing_ctl.sv
`timescale 1ns/1ps
module test_ide_pio_timing_ctl;
  typedef struct packed {
    logic       rdy;
    logic       bsy;
    logic       rd;
    logic       wr;
    logic       rsp;
    logic       csc;
    logic       csl;
    logic [2:0] a;
  } ent_t;

  localparam ent_t IDLE_ENT = '{rdy: 1'b1, default: '0};
  localparam logic [15:0] RD_VAL = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        busy;
  logic        ide_cs_cmd, ide_cs_ctl;
  logic [2:0]  ide_addr;
  logic        ide_rd, ide_wr;
  logic [15:0] ide_wdata;
  logic [15:0] ide_rdata = RD_VAL;
  logic        ide_iordy = 1'b1;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    mon_on = 1'b0;
  string tag_now = "R1";
  ent_t  exp_q[$];
  bit    iordy_q[$];

  always #10 clk = ~clk;

  ide_pio_timing_ctl i_ide_pio_timing_ctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .ide_cs_cmd(ide_cs_cmd), .ide_cs_ctl(ide_cs_ctl), .ide_addr(ide_addr),
    .ide_rd(ide_rd), .ide_wr(ide_wr), .ide_wdata(ide_wdata),
    .ide_rdata(ide_rdata), .ide_iordy(ide_iordy)
  );

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: one expected output word per clock, compared away from the edge
  always @(negedge clk) begin
    if (mon_on) begin
      ent_t e, got;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_ENT;
      got = '{rdy: req_ready, bsy: busy, rd: ide_rd, wr: ide_wr, rsp: rsp_valid,
              csc: ide_cs_cmd, csl: ide_cs_ctl, a: ide_addr};
      check(tag_now, got === e, 32'(got), 32'(e));
      if (e.rsp) check("R10 data", rsp_data === RD_VAL, 32'(rsp_data), 32'(RD_VAL));
      ide_iordy = (iordy_q.size() > 0) ? iordy_q.pop_front() : 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    @(negedge clk);
    check("R2 readback", cfg_rd_data === v, 32'(cfg_rd_data), 32'(v));
  endtask

  // a = strobe clocks (0: request not claimed), r = recovery clocks,
  // w = clocks IORDY is held low past the strobe period, ien = IORDY honoured
  task automatic xfer(input string tag, input bit we, input int addr, input logic [15:0] wd,
                      input int a, input int r, input int w, input bit ien,
                      input bit csc, input bit csl, input bit wait_done);
    int ext;
    ent_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = 10'(addr); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    tag_now = tag;
    if (a > 0) begin
      ext = ien ? w : 0;
      for (int i = 0; i < a + ext + r; i++) begin
        e = '0;
        e.bsy = 1'b1;
        e.csc = csc;
        e.csl = csl;
        e.a   = csl ? 3'd6 : 3'(addr);
        if (i < a + ext) begin
          e.rd = !we; e.wr = we;
        end else if (i == a + ext) begin
          e.rsp = !we;
        end
        exp_q.push_back(e);
      end
      if (w > 0) begin
        for (int i = 0; i < a - 1; i++) iordy_q.push_back(1'b1);
        for (int i = 0; i < w; i++) iordy_q.push_back(1'b0);
      end
    end
    if (wait_done) begin
      while (exp_q.size() != 0) @(posedge clk);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cfg", cfg_rd_data === 16'h0, 32'(cfg_rd_data), 0);
    check("R1 ready", req_ready === 1'b1, 32'(req_ready), 1);
    check("R1 busy", busy === 1'b0, 32'(busy), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tag_now = "R1 idle";
    repeat (3) @(negedge clk);

    // R3: channel off, claimed-looking addresses ignored
    xfer("R3 off", 1'b0, 'h1F0, 0, 0, 0, 0, 0, 0, 0, 1);
    xfer("R3 off ctl", 1'b1, 'h3F6, 0, 0, 0, 0, 0, 0, 0, 1);

    // R7/R4: primary, compatible timing
    cfg_write(16'h8000);
    xfer("R7 compat read", 1'b0, 'h1F0, 0, 8, 10, 0, 0, 1, 0, 1);
    xfer("R4 primary ctl", 1'b1, 'h3F6, 16'h0004, 8, 10, 0, 0, 0, 1, 1);
    xfer("R4 sec ignored", 1'b0, 'h170, 0, 0, 0, 0, 0, 0, 0, 1);
    xfer("R4 outside", 1'b0, 'h1E8, 0, 0, 0, 0, 0, 0, 0, 1);

    // R4: secondary window
    cfg_write(16'hC000);
    xfer("R4 secondary cmd", 1'b0, 'h177, 0, 8, 10, 0, 0, 1, 0, 1);
    xfer("R4 secondary ctl", 1'b0, 'h376, 0, 8, 10, 0, 0, 0, 1, 1);
    xfer("R4 pri ignored", 1'b1, 'h1F3, 0, 0, 0, 0, 0, 0, 0, 1);

    // R6: fast bank field codes
    cfg_write(16'h8000 | 16'h2000 | 16'h0100 | 16'h0001);
    xfer("R6 mid codes", 1'b0, 'h1F2, 0, 3, 3, 0, 0, 1, 0, 1);
    cfg_write(16'h8000 | 16'h3000 | 16'h0300 | 16'h0001);
    xfer("R6 shortest", 1'b1, 'h1F1, 16'h1234, 2, 1, 0, 0, 1, 0, 1);
    cfg_write(16'h8001);
    xfer("R6 longest", 1'b0, 'h1F7, 0, 5, 4, 0, 0, 1, 0, 1);

    // R2: unlisted and prefetch bits change nothing
    cfg_write(16'h8000 | 16'h2000 | 16'h0100 | 16'h0005 | 16'h0C80);
    xfer("R2 extra bits", 1'b0, 'h1F0, 0, 3, 3, 0, 0, 1, 0, 1);

    // R5: drive target switching
    cfg_write(16'h8000 | 16'h3300 | 16'h0001);
    xfer("R5 select uses old", 1'b1, 'h1F6, 16'h0010, 2, 1, 0, 0, 1, 0, 1);
    xfer("R5 drive1 compat", 1'b0, 'h1F0, 0, 8, 10, 0, 0, 1, 0, 1);
    cfg_write(16'h8000 | 16'h3300 | 16'h0010);
    xfer("R5 drive1 fast", 1'b0, 'h1F0, 0, 2, 1, 0, 0, 1, 0, 1);
    xfer("R5 back to 0 old", 1'b1, 'h1F6, 16'h0000, 2, 1, 0, 0, 1, 0, 1);
    xfer("R5 drive0 compat", 1'b0, 'h1F0, 0, 8, 10, 0, 0, 1, 0, 1);
    xfer("R5 ctl no select", 1'b1, 'h3F6, 16'h0010, 8, 10, 0, 0, 0, 1, 1);
    xfer("R5 still drive0", 1'b0, 'h1F0, 0, 8, 10, 0, 0, 1, 0, 1);

    // R8: IORDY wait handling
    cfg_write(16'h8000 | 16'h2000 | 16'h0100 | 16'h0003);
    xfer("R8 fast wait", 1'b0, 'h1F0, 0, 3, 3, 4, 1, 1, 0, 1);
    cfg_write(16'h8002);
    xfer("R8 compat wait", 1'b1, 'h1F5, 16'h00FF, 8, 10, 3, 1, 1, 0, 1);
    cfg_write(16'h8000 | 16'h2000 | 16'h0100 | 16'h0021);
    xfer("R8 ignored", 1'b0, 'h1F0, 0, 3, 3, 4, 0, 1, 0, 1);

    // R9/R11: back-to-back with request held through busy
    cfg_write(16'h8000 | 16'h3000 | 16'h0100 | 16'h0001);
    xfer("R9 first", 1'b1, 'h1F4, 16'hAAAA, 2, 3, 0, 0, 1, 0, 0);
    xfer("R9 held", 1'b0, 'h1F3, 0, 2, 3, 0, 0, 1, 0, 0);
    xfer("R11 third", 1'b1, 'h3F6, 16'h5555, 2, 3, 0, 0, 0, 1, 1);

    cfg_write(16'hFFFF);
    cfg_write(16'h0000);
    xfer("R3 off again", 1'b0, 'h1F0, 0, 0, 0, 0, 0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule